// File: doc/BRIEF.md
# Audio Codec Controller Register Front-End

This block is the processor-facing side of a stereo audio codec link controller. Software sees seven 32-bit-aligned registers. Two of them are sample FIFOs: one carries playback words toward the serial link engine, and the other returns recorded words from it. One register is a status byte. One register is a pair of FIFO clear strobes. The last three form a command path for accessing the codec's internal registers: a command register that holds the register index and the transfer direction, a read-data register and a write-data register.

The link side is a plain handshake. The link engine pulls a playback sample by pulsing `playReq`, and it pushes a recorded sample with `recValid`. For codec register accesses, the block holds `cmdReq` high together with the index, the direction and the write value until `cmdAck` returns. On a read, `cmdRdata` comes back in the same cycle as `cmdAck`. One access-finished flag serves both reads and writes. Two interrupt outputs let software keep the playback FIFO topped up and keep the record FIFO drained.

Top module: `audio_codec_front`

## Requirements
- R1: After reset, with `linkReady` high, the status byte (byte offset 0x08) reads 0x2A. `irqPlay` is 1, `irqRec` is 0 and `cmdReq` is 0.
- R2: A write to offset 0x00 appends bits 15:0 of the bus word to the playback FIFO. Each pulse of `playReq` removes one word, and the words come out on `playData` in the order they were written. The FIFO holds 32 words. A write made while 32 words are held is dropped. Status bit 0 is 1 exactly when 32 words are held.
- R3: Each cycle with `recValid` high appends `recData` to the record FIFO. A read of offset 0x04 returns the oldest word zero-extended to 32 bits and removes it. A read of an empty FIFO returns 0. Status bit 3 means empty and status bit 2 means full (32 words).
- R4: Status bit 1 and `irqPlay` are 1 while the playback FIFO holds 16 words or fewer.
- R5: `irqRec` is 1 while the record FIFO is not empty.
- R6: Status bit 6 (underrun) sets when `playReq` arrives while the playback FIFO is empty. It stays set until the playback FIFO is cleared.
- R7: Status bit 7 (overrun) sets when a record sample arrives while 32 words are held. That sample is dropped. The bit stays set until the record FIFO is cleared.
- R8: Writing offset 0x0C with bit 0 set clears the playback FIFO and underrun. Bit 1 set clears the record FIFO and overrun. Each bit leaves the other FIFO untouched, and both bits may be set in one write.
- R9: A write to offset 0x10 with bit 7 clear starts a codec write. `cmdReq` rises with `cmdRead` = 0, `cmdIndex` = bits 6:0, and `cmdWdata` = the value last written to offset 0x18 (bits 15:0). All four hold steady until `cmdAck`.
- R10: A write to offset 0x10 with bit 7 set starts a codec read with `cmdRead` = 1. On `cmdAck`, `cmdRdata` is captured and reads back at offset 0x14. Status bit 4 (access finished) sets in the same edge, for reads and for writes.
- R11: Accepting a new command clears status bit 4. A write to offset 0x10 while `cmdReq` is high is ignored. Offset 0x10 reads back the last accepted command, with the direction in bit 7 and the index in bits 6:0.
- R12: Status bit 5 follows the `linkReady` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address; bits 1:0 must be zero |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| irqPlay | output | 1 | Playback FIFO at or below half |
| irqRec | output | 1 | Record FIFO not empty |
| linkReady | input | 1 | Codec link is up |
| playReq | input | 1 | Link engine takes one playback word |
| playData | output | 16 | Oldest playback word (0 when empty) |
| recValid | input | 1 | Recorded word present |
| recData | input | 16 | Recorded word |
| cmdReq | output | 1 | Codec access pending |
| cmdRead | output | 1 | Pending access is a read |
| cmdIndex | output | 7 | Codec register index |
| cmdWdata | output | 16 | Value for a codec write |
| cmdAck | input | 1 | Link engine completes the access |
| cmdRdata | input | 16 | Codec read value, valid with cmdAck |

## Verification
The hardest situations to reach are the ones that sit right at a FIFO edge or inside the codec access window. Examples are a command arriving while one is still outstanding, and the ignored 33rd and 34th writes to a full FIFO. The bench fills each FIFO two words past capacity, one word at a time, and checks every flag at every fill level. It then drains each FIFO one step past empty. For the codec path it walks all 128 register indices with acknowledge latencies that rotate through 0 to 3 cycles. It also issues a second command deliberately, before the link model acknowledges the first.

// File: rtl/acf_pkg.sv
package acf_pkg;

  // Register select, taken from word address bits 4:2
  typedef enum logic [2:0] {
    SEL_PLAY = 3'd0,
    SEL_REC  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_RST  = 3'd3,
    SEL_CMD  = 3'd4,
    SEL_RDAT = 3'd5,
    SEL_WDAT = 3'd6,
    SEL_NONE = 3'd7
  } regSel_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic playPush;
    logic recPop;
    logic playClr;
    logic recClr;
    logic wdataLoad;
    logic cmdAccept;
    logic rdCapture;
  } acfStrobes_t;

  // Status bit positions (software decodes these)
  localparam int ST_OVERRUN  = 7;
  localparam int ST_UNDERRUN = 6;
  localparam int ST_READY    = 5;
  localparam int ST_DONE     = 4;
  localparam int ST_REMPTY   = 3;
  localparam int ST_RFULL    = 2;
  localparam int ST_PHALF    = 1;
  localparam int ST_PFULL    = 0;

  // Command register read-direction bit and clear-strobe bits
  localparam int CMD_RD_BIT    = 7;
  localparam int CLR_PLAY_BIT  = 0;
  localparam int CLR_REC_BIT   = 1;

endpackage

// File: rtl/acf_fifo.sv
module acf_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              pushOk, popOk;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/acf_ctrl.sv
module acf_ctrl
  import acf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrClrPlay,
  input  logic              wrClrRec,
  input  logic              wrRdBit,
  input  logic              cmdAck,
  output acfStrobes_t       strobes,
  output regSel_t           regSel,
  output logic              busy,
  output logic              accessDone
);

  typedef enum logic {CMD_IDLE, CMD_BUSY} cmdState_t;

  cmdState_t cmdState;
  logic      pendingRead;
  logic      aligned, doWrite, doRead;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign regSel  = aligned ? regSel_t'(busAddr[4:2]) : SEL_NONE;
  assign doWrite = busSel && busWrite;
  assign doRead  = busSel && !busWrite;
  assign busy    = (cmdState == CMD_BUSY);

  always_comb begin
    strobes           = '0;
    strobes.playPush  = doWrite && (regSel == SEL_PLAY);
    strobes.recPop    = doRead  && (regSel == SEL_REC);
    strobes.playClr   = doWrite && (regSel == SEL_RST) && wrClrPlay;
    strobes.recClr    = doWrite && (regSel == SEL_RST) && wrClrRec;
    strobes.wdataLoad = doWrite && (regSel == SEL_WDAT);
    strobes.cmdAccept = doWrite && (regSel == SEL_CMD) && !busy;
    strobes.rdCapture = busy && cmdAck && pendingRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdState    <= CMD_IDLE;
      pendingRead <= 1'b0;
      accessDone  <= 1'b0;
    end else begin
      case (cmdState)
        CMD_IDLE: if (strobes.cmdAccept) begin
          cmdState    <= CMD_BUSY;
          pendingRead <= wrRdBit;
          accessDone  <= 1'b0;
        end
        CMD_BUSY: if (cmdAck) begin
          cmdState   <= CMD_IDLE;
          accessDone <= 1'b1;
        end
        default: cmdState <= CMD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/acf_datapath.sv
module acf_datapath
  import acf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 7,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  acfStrobes_t         strobes,
  input  regSel_t             regSel,
  input  logic [SAMPLE_W-1:0] wrData,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                wrRdBit,
  input  logic                busy,
  input  logic                accessDone,
  input  logic                linkReady,
  input  logic                playReq,
  input  logic                recValid,
  input  logic [SAMPLE_W-1:0] recData,
  input  logic [SAMPLE_W-1:0] cmdRdata,
  output logic [31:0]         busRdata,
  output logic [SAMPLE_W-1:0] playData,
  output logic                irqPlay,
  output logic                irqRec,
  output logic                cmdRead,
  output logic [IDX_W-1:0]    cmdIndex,
  output logic [SAMPLE_W-1:0] cmdWdata,
  output logic [7:0]          statusWord
);

  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [SAMPLE_W-1:0] playHead, recHead, rdReg;
  logic [CNT_W-1:0]    playCnt, recCnt;
  logic                playEmpty, playFull, recEmpty, recFull;
  logic                underrun, overrun, playHalf;

  acf_fifo #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) u_playFifo (
    .clk(clk), .rstN(rstN), .clr(strobes.playClr),
    .push(strobes.playPush), .pushData(wrData), .pop(playReq),
    .head(playHead), .count(playCnt), .empty(playEmpty), .full(playFull)
  );

  acf_fifo #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) u_recFifo (
    .clk(clk), .rstN(rstN), .clr(strobes.recClr),
    .push(recValid), .pushData(recData), .pop(strobes.recPop),
    .head(recHead), .count(recCnt), .empty(recEmpty), .full(recFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
      cmdRead  <= 1'b0;
      cmdIndex <= '0;
      cmdWdata <= '0;
      rdReg    <= '0;
    end else begin
      if (strobes.playClr)               underrun <= 1'b0;
      else if (playReq && playEmpty)     underrun <= 1'b1;
      if (strobes.recClr)                overrun  <= 1'b0;
      else if (recValid && recFull)      overrun  <= 1'b1;
      if (strobes.cmdAccept) begin
        cmdRead  <= wrRdBit;
        cmdIndex <= wrIdx;
      end
      if (strobes.wdataLoad && !busy)    cmdWdata <= wrData;
      if (strobes.rdCapture)             rdReg    <= cmdRdata;
    end
  end

  assign recCntUnused = recCnt[0];
  assign playHalf = (playCnt <= HALF_CNT);
  assign irqPlay  = playHalf;
  assign irqRec   = !recEmpty;
  assign playData = playEmpty ? '0 : playHead;

  always_comb begin
    statusWord              = '0;
    statusWord[ST_OVERRUN]  = overrun;
    statusWord[ST_UNDERRUN] = underrun;
    statusWord[ST_READY]    = linkReady;
    statusWord[ST_DONE]     = accessDone;
    statusWord[ST_REMPTY]   = recEmpty;
    statusWord[ST_RFULL]    = recFull;
    statusWord[ST_PHALF]    = playHalf;
    statusWord[ST_PFULL]    = playFull;
  end

  always_comb begin
    case (regSel)
      SEL_REC:  busRdata = 32'(recEmpty ? '0 : recHead);
      SEL_STAT: busRdata = 32'(statusWord);
      SEL_CMD:  busRdata = 32'({cmdRead, 7'(cmdIndex)});
      SEL_RDAT: busRdata = 32'(rdReg);
      SEL_WDAT: busRdata = 32'(cmdWdata);
      default:  busRdata = '0;
    endcase
  end

  logic recCntUnused;

endmodule

// File: rtl/audio_codec_front.sv
module audio_codec_front
  import acf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 7,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqPlay,
  output logic                irqRec,
  input  logic                linkReady,
  input  logic                playReq,
  output logic [SAMPLE_W-1:0] playData,
  input  logic                recValid,
  input  logic [SAMPLE_W-1:0] recData,
  output logic                cmdReq,
  output logic                cmdRead,
  output logic [IDX_W-1:0]    cmdIndex,
  output logic [SAMPLE_W-1:0] cmdWdata,
  input  logic                cmdAck,
  input  logic [SAMPLE_W-1:0] cmdRdata
);

  acfStrobes_t strobes;
  regSel_t     regSel;
  logic        busy, accessDone;
  logic [7:0]  statusWord;

  assign cmdReq = busy;

  acf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .wrClrPlay(busWdata[CLR_PLAY_BIT]), .wrClrRec(busWdata[CLR_REC_BIT]),
    .wrRdBit(busWdata[CMD_RD_BIT]), .cmdAck(cmdAck),
    .strobes(strobes), .regSel(regSel), .busy(busy), .accessDone(accessDone)
  );

  acf_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel),
    .wrData(busWdata[SAMPLE_W-1:0]), .wrIdx(busWdata[IDX_W-1:0]),
    .wrRdBit(busWdata[CMD_RD_BIT]), .busy(busy), .accessDone(accessDone),
    .linkReady(linkReady), .playReq(playReq), .recValid(recValid),
    .recData(recData), .cmdRdata(cmdRdata), .busRdata(busRdata),
    .playData(playData), .irqPlay(irqPlay), .irqRec(irqRec),
    .cmdRead(cmdRead), .cmdIndex(cmdIndex), .cmdWdata(cmdWdata),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/acf_checker.sv
module acf_checker #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              irqPlay,
  input logic              irqRec,
  input logic              recValid,
  input logic              cmdReq,
  input logic              cmdRead,
  input logic [IDX_W-1:0]  cmdIndex,
  input logic              cmdAck,
  input logic              accessDone,
  input logic [7:0]        statusWord
);

  logic wrPlay, wrRst, wrCmd;
  assign wrPlay = busSel && busWrite && (busAddr == ADDR_W'(8'h00));
  assign wrRst  = busSel && busWrite && (busAddr == ADDR_W'(8'h0C));
  assign wrCmd  = busSel && busWrite && (busAddr == ADDR_W'(8'h10));

  // R9: an outstanding request holds its fields until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdAck |=> cmdReq && $stable(cmdIndex) && $stable(cmdRead));

  // R10: acknowledge completes the access and raises the finished flag
  assert_ack_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && cmdAck |=> !cmdReq && accessDone);

  // R11: a command written while busy changes nothing
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && wrCmd |=> $stable(cmdIndex) && $stable(cmdRead));

  // R4: playback interrupt can only drop after a playback write
  assert_half_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPlay) |-> $past(wrPlay));

  // R5: record interrupt can only rise after a record sample arrives
  assert_rec_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqRec) |-> $past(recValid));

  // R6: underrun is sticky until a playback clear
  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6] && !(wrRst && busWdata[0]) |=> statusWord[6]);

  // R7: overrun is sticky until a record clear
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[7] && !(wrRst && busWdata[1]) |=> statusWord[7]);

endmodule

bind audio_codec_front acf_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .irqPlay(irqPlay), .irqRec(irqRec),
  .recValid(recValid), .cmdReq(cmdReq), .cmdRead(cmdRead),
  .cmdIndex(cmdIndex), .cmdAck(cmdAck), .accessDone(accessDone),
  .statusWord(statusWord)
);

// File: tb/tb_audio_codec_front.sv
`timescale 1ns/1ps
module tb_audio_codec_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqPlay, irqRec;
  logic        linkReady = 1'b1;
  logic        playReq = 1'b0;
  logic [15:0] playData;
  logic        recValid = 1'b0;
  logic [15:0] recData = '0;
  logic        cmdReq, cmdRead;
  logic [6:0]  cmdIndex;
  logic [15:0] cmdWdata;
  logic        cmdAck = 1'b0;
  logic [15:0] cmdRdata = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  audio_codec_front dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqPlay(irqPlay), .irqRec(irqRec), .linkReady(linkReady),
    .playReq(playReq), .playData(playData), .recValid(recValid),
    .recData(recData), .cmdReq(cmdReq), .cmdRead(cmdRead),
    .cmdIndex(cmdIndex), .cmdWdata(cmdWdata), .cmdAck(cmdAck),
    .cmdRdata(cmdRdata)
  );

  function automatic logic [15:0] playVal(int n);
    return 16'(n * 291 + 1024);
  endfunction
  function automatic logic [15:0] recVal(int n);
    return 16'(n * 16'h0A5B) ^ 16'h3C00;
  endfunction
  function automatic logic [15:0] codecVal(int idx);
    return {7'(idx), 9'h000} ^ 16'h5A5A;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic linkPop(output logic [15:0] d);
    @(negedge clk);
    playReq = 1'b1;
    #1 d = playData;
    @(negedge clk);
    playReq = 1'b0;
  endtask

  task automatic linkPush(logic [15:0] v);
    @(negedge clk);
    recValid = 1'b1; recData = v;
    @(negedge clk);
    recValid = 1'b0;
  endtask

  task automatic codecServe(int lat, logic [15:0] v);
    while (!cmdReq) @(negedge clk);
    repeat (lat) @(negedge clk);
    cmdAck = 1'b1; cmdRdata = v;
    @(negedge clk);
    cmdAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] p;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(5'h08, r);
    chk("R1 status", r, 32'h2A);
    chk("R1 irqPlay", 32'(irqPlay), 1);
    chk("R1 irqRec", 32'(irqRec), 0);
    chk("R1 cmdReq", 32'(cmdReq), 0);

    // R12 ready follows input
    linkReady = 1'b0;
    busRd(5'h08, r);
    chk("R12 ready low", 32'(r[5]), 0);
    linkReady = 1'b1;
    busRd(5'h08, r);
    chk("R12 ready high", 32'(r[5]), 1);

    // R2/R4 playback fill sweep past capacity
    for (int n = 1; n <= 34; n++) begin
      busWr(5'h00, {16'hDEAD, playVal(n)});
      cnt = (n > 32) ? 32 : n;
      busRd(5'h08, r);
      chk("R2 play full bit", 32'(r[0]), 32'(cnt == 32));
      chk("R4 play half bit", 32'(r[1]), 32'(cnt <= 16));
      chk("R4 irqPlay", 32'(irqPlay), 32'(cnt <= 16));
    end
    // R2 drain in order; words 33,34 were dropped
    for (int n = 1; n <= 32; n++) begin
      linkPop(p);
      chk("R2 play order", 32'(p), 32'(playVal(n)));
      chk("R4 irqPlay drain", 32'(irqPlay), 32'((32 - n) <= 16));
    end
    busRd(5'h08, r);
    chk("R6 no underrun yet", 32'(r[6]), 0);
    linkPop(p);
    chk("R2 empty data zero", 32'(p), 0);
    busRd(5'h08, r);
    chk("R6 underrun set", 32'(r[6]), 1);
    busWr(5'h00, 32'h1234);
    busRd(5'h08, r);
    chk("R6 underrun sticky", 32'(r[6]), 1);
    busWr(5'h0C, 32'h2);
    busRd(5'h08, r);
    chk("R8 rec clear keeps underrun", 32'(r[6]), 1);
    busWr(5'h0C, 32'h1);
    busRd(5'h08, r);
    chk("R6 underrun cleared", 32'(r[6]), 0);
    linkPop(p);
    busRd(5'h08, r);
    chk("R8 play clear emptied", 32'(r[6]), 1);
    busWr(5'h0C, 32'h1);

    // R3/R5/R7 record fill sweep
    chk("R5 irqRec idle", 32'(irqRec), 0);
    for (int n = 1; n <= 34; n++) begin
      linkPush(recVal(n));
      cnt = (n > 32) ? 32 : n;
      busRd(5'h08, r);
      chk("R3 rec empty bit", 32'(r[3]), 0);
      chk("R3 rec full bit", 32'(r[2]), 32'(cnt == 32));
      chk("R7 overrun bit", 32'(r[7]), 32'(n > 32));
      chk("R5 irqRec", 32'(irqRec), 1);
    end
    for (int n = 1; n <= 32; n++) begin
      busRd(5'h04, r);
      chk("R3 rec order", r, 32'(recVal(n)));
    end
    busRd(5'h04, r);
    chk("R3 rec empty read", r, 0);
    busRd(5'h08, r);
    chk("R3 rec empty", 32'(r[3]), 1);
    chk("R5 irqRec drained", 32'(irqRec), 0);
    busWr(5'h0C, 32'h1);
    busRd(5'h08, r);
    chk("R8 play clear keeps overrun", 32'(r[7]), 1);
    busWr(5'h0C, 32'h2);
    busRd(5'h08, r);
    chk("R7 overrun cleared", 32'(r[7]), 0);

    // R8 independence and combined clear
    for (int n = 0; n < 20; n++) busWr(5'h00, 32'(n));
    linkPush(16'h7777);
    busWr(5'h0C, 32'h2);
    busRd(5'h08, r);
    chk("R8 rec cleared", 32'(r[3]), 1);
    chk("R8 play untouched", 32'(r[1]), 0);
    linkPush(16'h8888);
    busWr(5'h0C, 32'h1);
    busRd(5'h08, r);
    chk("R8 play cleared", 32'(r[1]), 1);
    chk("R8 rec untouched", 32'(irqRec), 1);
    busWr(5'h00, 32'h5);
    busWr(5'h0C, 32'h3);
    linkPop(p);
    busRd(5'h08, r);
    chk("R8 both cleared", r & 32'h4F, 32'h4A);
    busWr(5'h0C, 32'h1);

    // R9 codec write
    busWr(5'h18, 32'hFFFF_1234);
    busWr(5'h10, 32'h0000_0026);
    chk("R9 req", 32'(cmdReq), 1);
    chk("R9 dir", 32'(cmdRead), 0);
    chk("R9 idx", 32'(cmdIndex), 32'h26);
    chk("R9 wdata", 32'(cmdWdata), 32'h1234);
    repeat (3) @(negedge clk);
    chk("R9 req held", 32'(cmdReq), 1);
    busRd(5'h08, r);
    chk("R11 done clear while busy", 32'(r[4]), 0);
    codecServe(0, 16'h0);
    busRd(5'h08, r);
    chk("R10 done after write", 32'(r[4]), 1);
    chk("R9 req drop", 32'(cmdReq), 0);

    // R11 command while busy is ignored
    busWr(5'h10, 32'h9C);
    busWr(5'h10, 32'h05);
    chk("R11 idx kept", 32'(cmdIndex), 32'h1C);
    chk("R11 dir kept", 32'(cmdRead), 1);
    codecServe(2, 16'hBEEF);
    busRd(5'h10, r);
    chk("R11 cmd readback", r, 32'h9C);
    busRd(5'h14, r);
    chk("R10 rdata", r, 32'hBEEF);

    // R10 sweep over all indices with rotating ack latency
    for (int idx = 0; idx < 128; idx++) begin
      busWr(5'h10, 32'h80 | 32'(idx));
      chk("R10 sweep dir/idx", {cmdRead, cmdIndex}, 32'h80 | 32'(idx));
      codecServe(idx % 4, codecVal(idx));
      busRd(5'h14, r);
      chk("R10 sweep rdata", r, 32'(codecVal(idx)));
      busRd(5'h08, r);
      chk("R10 sweep done", 32'(r[4]), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule